// File: doc/BRIEF.md
# Reversible-Gate Magnitude Comparator

This block compares two unsigned operands, `op_a` and `op_b`, and raises one of three result flags: equal, greater or less. It has no clock and no state. The comparison is built only from small primitive cells whose outputs can be inverted back to their inputs: an inverter, a controlled NOT with any number of controls, a three-line "difference" cell and a three-line "or-accumulate" cell. Each cell has as many outputs as inputs. Every line of the network is tracked from input to output, so no value is copied by wire fan-out between cells.

Each bit position has one slice. The difference cell, with a cleared ancilla, yields `a XOR b` and `a AND NOT b`. An inverter turns the first of these into the bit-equality term. A wide controlled NOT on a cleared ancilla forms the equal flag. The greater flag is built up on the MSB's `a AND NOT b` line: a chain of controlled NOTs adds each lower-order term, gated by the equality terms above it. The terms are mutually exclusive, so XOR gives the same result as OR here. An or-accumulate cell with a set ancilla then forms the less flag as NOR(equal, greater). Lines that carry no result leave the block on a single garbage bus. For the default width of 4, the network has 13 cells and 6 ancillas: 8 operand lines plus 6 ancillas come out as 3 flags plus 11 garbage lines.

Top module: `rev_mag_cmp`

## Requirements
- R1: `o_eq` is 1 exactly when `op_a` equals `op_b`.
- R2: `o_gt` is 1 exactly when `op_a` is greater than `op_b`, both read as unsigned numbers.
- R3: `o_lt` is 1 exactly when `op_a` is less than `op_b`, both read as unsigned numbers.
- R4: For every operand pair, exactly one of `o_eq`, `o_gt`, `o_lt` is 1.
- R5: `o_garbage` is 3W-1 bits wide (11 at W=4). Bits [W-1:0] repeat `op_a`. Bits [2W-1:W] hold the per-bit equality terms, bit W+i = NOT(a_i XOR b_i). Bits [3W-2:2W] hold a_i AND NOT b_i for i = 0..W-2, with bit 2W+i carrying bit i.
- R6: The difference cell maps inputs (k, s, c) to outputs (k, k XOR s, (k AND NOT s) XOR c).
- R7: The or-accumulate cell maps inputs (x, y, c) to outputs (x, y, (x OR y) XOR c).
- R8: The controlled-NOT cell passes its controls through unchanged. It inverts its target only when every control is 1.
- R9: The inverter cell drives the complement of its single input.
- R10: Each primitive cell is a bijection: no two input patterns give the same output vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First unsigned operand |
| op_b | input | W | Second unsigned operand |
| o_eq | output | 1 | Operands are equal |
| o_gt | output | 1 | op_a is greater than op_b |
| o_lt | output | 1 | op_a is less than op_b |
| o_garbage | output | 3W-1 | Lines of the network that carry no result |

## Verification
The bench runs every one of the 256 operand pairs. Several cases get particular attention. Pairs that differ only in the LSB depend on the widest gating term; a stage wired to the wrong equality line would give a wrong greater or less flag on those pairs. Pairs that differ in the MSB must ignore all lower bits; a network that ORs the terms with the wrong gating would raise two flags at once. A cell with a mistaken ancilla constant would flip a whole flag or a garbage field across the board. Each primitive cell is also driven through its full input space on its own. Any cell that loses information makes two patterns collide, and the bench reports the collision.

// File: rtl/rev_cmp_pkg.sv
package rev_cmp_pkg;

    localparam int unsigned CMP_W_DEF = 4;

    // ancilla constants fed into the network
    localparam logic ANC_CLEAR = 1'b0;
    localparam logic ANC_SET   = 1'b1;

    // width of the garbage bus for a given operand width
    function automatic int unsigned garb_width(input int unsigned w);
        return 3 * w - 1;
    endfunction

    typedef struct packed {
        logic eq;
        logic gt;
        logic lt;
    } cmp_flags_t;

endpackage

// File: rtl/rev_prims.sv
// Primitive reversible cells: equal input and output count, bijective maps.

module rev_not (
    input  logic i_bit,
    output logic o_bit
);
    assign o_bit = ~i_bit;

    always_comb begin
        assert_not_inv_R9: assert (o_bit != i_bit)
            else $error("inverter output equals input");
    end
endmodule

module rev_tr (
    input  logic i_keep,
    input  logic i_sub,
    input  logic i_acc,
    output logic o_keep,
    output logic o_diff,
    output logic o_acc
);
    assign o_keep = i_keep;
    assign o_diff = i_keep ^ i_sub;
    assign o_acc  = (i_keep & ~i_sub) ^ i_acc;

    // inverse map recovers the inputs (R6, R10)
    always_comb begin
        assert_tr_inverse_R6: assert ({o_keep, o_keep ^ o_diff,
                                       o_acc ^ (o_keep & ~(o_keep ^ o_diff))}
                                      == {i_keep, i_sub, i_acc})
            else $error("difference cell not invertible");
    end
endmodule

module rev_bjn (
    input  logic i_x,
    input  logic i_y,
    input  logic i_acc,
    output logic o_x,
    output logic o_y,
    output logic o_acc
);
    assign o_x   = i_x;
    assign o_y   = i_y;
    assign o_acc = (i_x | i_y) ^ i_acc;

    always_comb begin
        assert_bjn_flip_R7: assert ((o_acc != i_acc) == (o_x | o_y))
            else $error("or-accumulate cell flipped wrongly");
    end
endmodule

module rev_mct #(
    parameter int unsigned NCTL = 2
) (
    input  logic [NCTL-1:0] i_ctl,
    input  logic            i_tgt,
    output logic [NCTL-1:0] o_ctl,
    output logic            o_tgt
);
    assign o_ctl = i_ctl;
    assign o_tgt = i_tgt ^ (&i_ctl);

    always_comb begin
        assert_mct_gate_R8: assert ((o_tgt == i_tgt) || (&o_ctl))
            else $error("controlled NOT flipped with a control low");
    end
endmodule

// File: rtl/rev_cmp_slice.sv
// One bit position: difference cell with cleared ancilla, then inverter.
module rev_cmp_slice
    import rev_cmp_pkg::*;
(
    input  logic i_a,
    input  logic i_b,
    output logic o_a_line,
    output logic o_x_line,
    output logic o_g_line
);
    logic diff_line;

    rev_tr u_tr (
        .i_keep (i_a),
        .i_sub  (i_b),
        .i_acc  (ANC_CLEAR),
        .o_keep (o_a_line),
        .o_diff (diff_line),
        .o_acc  (o_g_line)
    );

    rev_not u_not (
        .i_bit (diff_line),
        .o_bit (o_x_line)
    );

    always_comb begin
        assert_slice_match_R5: assert (o_x_line == (i_a == i_b))
            else $error("bit equality term wrong");
        assert_slice_greater_R5: assert (o_g_line == (i_a > i_b))
            else $error("bit greater term wrong");
    end
endmodule

// File: rtl/rev_mag_cmp.sv
module rev_mag_cmp
    import rev_cmp_pkg::*;
#(
    parameter int unsigned W = CMP_W_DEF
) (
    input  logic [W-1:0]                op_a,
    input  logic [W-1:0]                op_b,
    output logic                        o_eq,
    output logic                        o_gt,
    output logic                        o_lt,
    output logic [garb_width(W)-1:0]    o_garbage
);
    localparam int unsigned GW = garb_width(W);

    logic [W-1:0] a_line;
    logic [W-1:0] x_raw;
    logic [W-1:0] g_line;

    // per-bit slices
    for (genvar i = 0; i < W; i++) begin : g_slice
        rev_cmp_slice u_slice (
            .i_a      (op_a[i]),
            .i_b      (op_b[i]),
            .o_a_line (a_line[i]),
            .o_x_line (x_raw[i]),
            .o_g_line (g_line[i])
        );
    end

    // equality lines after each cell that uses them as controls
    logic [W-1:0] xl [W];
    logic         eq_raw;

    rev_mct #(.NCTL(W)) u_eq (
        .i_ctl (x_raw),
        .i_tgt (ANC_CLEAR),
        .o_ctl (xl[W-1]),
        .o_tgt (eq_raw)
    );

    // greater flag accumulated on the MSB difference line
    logic [W-1:0] gt_chain;
    logic [W-2:0] g_keep;

    assign gt_chain[W-1] = g_line[W-1];

    for (genvar i = 0; i < W - 1; i++) begin : g_gt_stage
        logic [W-i-1:0] st_ctl;

        rev_mct #(.NCTL(W - i)) u_stage (
            .i_ctl ({xl[i+1][W-1:i+1], g_line[i]}),
            .i_tgt (gt_chain[i+1]),
            .o_ctl (st_ctl),
            .o_tgt (gt_chain[i])
        );

        assign g_keep[i] = st_ctl[0];
        assign xl[i]     = {st_ctl[W-i-1:1], xl[i+1][i:0]};
    end

    // less flag = NOR(eq, gt) through the or-accumulate cell
    cmp_flags_t flags;

    rev_bjn u_lt (
        .i_x   (eq_raw),
        .i_y   (gt_chain[0]),
        .i_acc (ANC_SET),
        .o_x   (flags.eq),
        .o_y   (flags.gt),
        .o_acc (flags.lt)
    );

    assign o_eq      = flags.eq;
    assign o_gt      = flags.gt;
    assign o_lt      = flags.lt;
    assign o_garbage = GW'({g_keep, xl[0], a_line});

    always_comb begin
        assert_eq_flag_R1: assert (o_eq == (op_a == op_b))
            else $error("equal flag wrong");
        assert_gt_flag_R2: assert (o_gt == (op_a > op_b))
            else $error("greater flag wrong");
        assert_lt_flag_R3: assert (o_lt == (op_a < op_b))
            else $error("less flag wrong");
        assert_one_flag_R4: assert ($onehot({o_eq, o_gt, o_lt}))
            else $error("flags not one-hot");
        assert_garb_copy_R5: assert (o_garbage[W-1:0] == op_a)
            else $error("garbage operand copy wrong");
    end
endmodule

// File: tb/rev_mag_cmp_tb.sv
module rev_mag_cmp_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // comparator under test
    logic [3:0]  a, b;
    logic        eq, gt, lt;
    logic [10:0] garb;

    rev_mag_cmp dut_i (
        .op_a      (a),
        .op_b      (b),
        .o_eq      (eq),
        .o_gt      (gt),
        .o_lt      (lt),
        .o_garbage (garb)
    );

    // standalone primitives
    logic [2:0] tr_in, tr_out, bj_in, bj_out;
    logic [3:0] mc_in, mc_out;
    logic       nt_in, nt_out;

    rev_tr u_tr (.i_keep(tr_in[2]), .i_sub(tr_in[1]), .i_acc(tr_in[0]),
                 .o_keep(tr_out[2]), .o_diff(tr_out[1]), .o_acc(tr_out[0]));
    rev_bjn u_bj (.i_x(bj_in[2]), .i_y(bj_in[1]), .i_acc(bj_in[0]),
                  .o_x(bj_out[2]), .o_y(bj_out[1]), .o_acc(bj_out[0]));
    rev_mct #(.NCTL(3)) u_mc (.i_ctl(mc_in[3:1]), .i_tgt(mc_in[0]),
                              .o_ctl(mc_out[3:1]), .o_tgt(mc_out[0]));
    rev_not u_nt (.i_bit(nt_in), .o_bit(nt_out));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        a = '0; b = '0;
        tr_in = '0; bj_in = '0; mc_in = '0; nt_in = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // start state with zero operands: R1 equal only
        chk(eq == 1'b1 && gt == 1'b0 && lt == 1'b0, "R1 start",
            int'({eq, gt, lt}), 4);

        // exhaustive operand sweep
        for (int ia = 0; ia < 16; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                int exp_g;
                @(posedge clk);
                a = 4'(ia); b = 4'(ib);
                @(negedge clk);
                chk(eq == (ia == ib), "R1", int'(eq), int'(ia == ib));
                chk(gt == (ia > ib),  "R2", int'(gt), int'(ia > ib));
                chk(lt == (ia < ib),  "R3", int'(lt), int'(ia < ib));
                chk(int'(eq) + int'(gt) + int'(lt) == 1, "R4",
                    int'(eq) + int'(gt) + int'(lt), 1);
                exp_g = (((ia & ~ib) & 7) << 8) | ((~(ia ^ ib) & 15) << 4) | ia;
                chk(int'(garb) == exp_g, "R5", int'(garb), exp_g);
            end
        end
        chk($bits(garb) == 11, "R5 width", $bits(garb), 11);

        // difference cell: function and bijection
        begin
            bit [7:0] seen = '0;
            for (int p = 0; p < 8; p++) begin
                int k, s, c, e;
                @(posedge clk);
                tr_in = 3'(p);
                @(negedge clk);
                k = (p >> 2) & 1; s = (p >> 1) & 1; c = p & 1;
                e = (k << 2) | ((k ^ s) << 1) | ((k & (1 - s)) ^ c);
                chk(int'(tr_out) == e, "R6", int'(tr_out), e);
                chk(!seen[tr_out], "R10 diff cell", int'(tr_out), p);
                seen[tr_out] = 1'b1;
            end
        end

        // or-accumulate cell
        begin
            bit [7:0] seen = '0;
            for (int p = 0; p < 8; p++) begin
                int x, y, c, e;
                @(posedge clk);
                bj_in = 3'(p);
                @(negedge clk);
                x = (p >> 2) & 1; y = (p >> 1) & 1; c = p & 1;
                e = (x << 2) | (y << 1) | ((x | y) ^ c);
                chk(int'(bj_out) == e, "R7", int'(bj_out), e);
                chk(!seen[bj_out], "R10 or cell", int'(bj_out), p);
                seen[bj_out] = 1'b1;
            end
        end

        // three-control NOT
        begin
            bit [15:0] seen = '0;
            for (int p = 0; p < 16; p++) begin
                int e;
                @(posedge clk);
                mc_in = 4'(p);
                @(negedge clk);
                e = ((p >> 1) == 7) ? (p ^ 1) : p;
                chk(int'(mc_out) == e, "R8", int'(mc_out), e);
                chk(!seen[mc_out], "R10 cnot", int'(mc_out), p);
                seen[mc_out] = 1'b1;
            end
        end

        // inverter
        for (int p = 0; p < 2; p++) begin
            @(posedge clk);
            nt_in = 1'(p);
            @(negedge clk);
            chk(int'(nt_out) == 1 - p, "R9", int'(nt_out), 1 - p);
        end

        finish_run();
    end

endmodule